// File: doc/BRIEF.md
# SMBus Register Slave with Block Mode

This block is the serial front end for a small bank of 8-bit control registers. It oversamples the two-wire bus lines with a fast system clock. It detects start, repeated start and stop conditions, and it pulls SDA low for acknowledge bits and for data sent back to the master. The register storage is outside the block. This block only issues a write strobe with an address and data, and it presents a read address whose data is returned combinationally on `rd_data`.

Bit 7 of the command byte picks one of two access styles:
- **Indexed single-byte access** uses the offset held in the low seven bits.
- **Sequential block access** always starts at offset 0 and moves upward.

A block write normally carries a count byte ahead of its data. A configuration input removes that count byte. A block read always returns the bank length first and then the register contents. A one-cycle completion pulse follows the stop condition of any transaction that wrote a register, so that logic with self-clearing bits can act on it.

Top module: `smb_regslave`

## Requirements
- R1: The slave acknowledges the address byte D2h (7-bit address 69h, write) and D3h (read). Any other address byte gets no acknowledge, and the slave then ignores the bus until the next start condition.
- R2: A command byte with bit 7 = 1 selects single-byte access at the offset in bits 6:0. A data byte aimed at an offset of NUM_REGS or above gets no acknowledge and is not written.
- R3: In a single-byte write, the first data byte is acknowledged and appears on the write port. A second data byte in the same transaction gets no acknowledge and is not written.
- R4: A single-byte read is done by writing the command, then sending a repeated start and D3h. The slave returns the register at the selected offset, most significant bit first.
- R5: A command byte with bit 7 = 0 selects block access starting at offset 0 and ascending. In a block write with `skip_count` = 0, the byte after the command is a count: it is acknowledged and never written. With `skip_count` = 1, that byte is the data for offset 0.
- R6: A block write may be ended by a stop after any complete byte, and only the bytes actually sent are written. Data bytes beyond the last register get no acknowledge and are not written.
- R7: A block read returns the count NUM_REGS first. It then returns the registers from offset 0 upward until the master sends a NACK. Reads past the end return FFh.
- R8: `xfer_done` pulses for one cycle after the stop of a transaction that wrote at least one register. It never pulses for a read-only or rejected transaction.
- R9: `sda_oe` is 0 after reset and changes only in response to a falling SCL edge, a start condition or a stop condition.
- R10: `wr_en` is a single-cycle pulse per accepted data byte, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| skip_count | input | 1 | 1 removes the count byte from block writes |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | AW | Register write offset |
| wr_data | output | 8 | Register write data |
| rd_addr | output | AW | Register read offset |
| rd_data | input | 8 | Register contents at `rd_addr` |
| xfer_done | output | 1 | Pulse after the stop of a writing transaction |

## Verification
The embedded assertions check the cycle-level rules on every cycle:
- the data-line driver moves only on a falling SCL edge or on a bus condition;
- write strobes are single pulses tied to a falling SCL edge;
- the completion pulse follows a detected stop.

Only the bench scenarios can show the protocol meaning: which bytes are acknowledged, where block writes land, the count byte with and without `skip_count`, early stops, reads past the end, and the silence after a foreign address. The bench checks these by comparing its own register model against values read back over the bus.

// File: rtl/smb_regslave_pkg.sv
package smb_regslave_pkg;
    // Protocol phases of the transfer engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_CNT,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } smb_state_e;

    // Value returned when a read runs past the end of the bank.
    localparam logic [7:0] READ_FILL = 8'hFF;
endpackage

// File: rtl/smb_line_mon.sv
// Bus line monitor.
// Passes SCL and SDA through SYNC_STAGES flops, keeps one extra delayed copy
// of each, and reports SCL edges and start/stop conditions as one-cycle events.
// Assumes the bus idles high and changes much slower than clk.
module smb_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_STAGES:0] scl_sh;
    logic [SYNC_STAGES:0] sda_sh;
    logic scl_s, scl_d, sda_d;

    // Synchroniser chains plus one delay stage, reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign scl_d = scl_sh[SYNC_STAGES];
    assign sda_s = sda_sh[SYNC_STAGES-1];
    assign sda_d = sda_sh[SYNC_STAGES];

    // Edge and condition decode on the synchronised lines.
    always_comb begin
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_ev = scl_s & scl_d & sda_d & ~sda_s;
        stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/smb_xfer_fsm.sv
// Transfer engine.
// Shifts bytes in on rising SCL and drives acknowledges and read data on
// falling SCL. Decodes address, command and count, and generates the register
// port strobes and the completion pulse.
// Assumes rd_data is valid combinationally for rd_addr, and that
// NUM_REGS <= 127.
module smb_xfer_fsm
    import smb_regslave_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h69,
    parameter int         NUM_REGS = 8,
    parameter int         AW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic          skip_count,
    input  logic [7:0]    rd_data,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_addr,
    output logic          done
);
    localparam logic [7:0] BANK_LEN = 8'(NUM_REGS);

    smb_state_e state;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] ptr;
    logic       in_ack, nack_seen, byte_mode, byte_used, cnt_pending, wrote;
    logic       ptr_ok, accept;
    logic [7:0] tx_byte;

    assign rd_addr = ptr[AW-1:0];
    assign ptr_ok  = (ptr < BANK_LEN);
    assign accept  = ptr_ok && !(byte_mode && byte_used);

    // Next byte to transmit: the count first in block reads, then register data.
    always_comb begin
        if (cnt_pending)  tx_byte = BANK_LEN;
        else if (ptr_ok)  tx_byte = rd_data;
        else              tx_byte = READ_FILL;
    end

    // Protocol state, shifter and port strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            ptr         <= '0;
            in_ack      <= 1'b0;
            nack_seen   <= 1'b0;
            byte_mode   <= 1'b0;
            byte_used   <= 1'b0;
            cnt_pending <= 1'b0;
            wrote       <= 1'b0;
            sda_oe      <= 1'b0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            done        <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            done  <= 1'b0;
            if (start_ev) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
                done   <= wrote;
                wrote  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
                        if (in_ack) begin
                            if (scl_fall) begin
                                in_ack  <= 1'b0;
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end
                        end else if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            in_ack  <= 1'b1;
                            bit_cnt <= '0;
                            case (state)
                                ST_ADDR: begin
                                    if (shreg[7:1] == SLV_ADDR) begin
                                        sda_oe    <= 1'b1;
                                        nack_seen <= 1'b0;
                                        state     <= shreg[0] ? ST_RDATA : ST_CMD;
                                    end else begin
                                        in_ack <= 1'b0;
                                        state  <= ST_SKIP;
                                    end
                                end
                                ST_CMD: begin
                                    sda_oe    <= 1'b1;
                                    byte_mode <= shreg[7];
                                    byte_used <= 1'b0;
                                    if (shreg[7]) begin
                                        ptr         <= {1'b0, shreg[6:0]};
                                        cnt_pending <= 1'b0;
                                        state       <= ST_WDATA;
                                    end else begin
                                        ptr         <= '0;
                                        cnt_pending <= 1'b1;
                                        state       <= skip_count ? ST_WDATA : ST_CNT;
                                    end
                                end
                                ST_CNT: begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_WDATA;
                                end
                                default: begin
                                    sda_oe <= accept;
                                    if (accept) begin
                                        wr_en     <= 1'b1;
                                        wr_addr   <= ptr[AW-1:0];
                                        wr_data   <= shreg;
                                        wrote     <= 1'b1;
                                        byte_used <= 1'b1;
                                        ptr       <= ptr + 8'd1;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_RDATA: begin
                        if (in_ack) begin
                            // The slave's own ack samples as 0; a master NACK samples as 1.
                            if (scl_rise) begin
                                nack_seen <= sda_s;
                            end else if (scl_fall) begin
                                in_ack <= 1'b0;
                                if (nack_seen) begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_SKIP;
                                end else begin
                                    shreg   <= tx_byte;
                                    sda_oe  <= ~tx_byte[7];
                                    bit_cnt <= 4'd1;
                                    if (cnt_pending)          cnt_pending <= 1'b0;
                                    else if (ptr != 8'hFF)    ptr <= ptr + 8'd1;
                                end
                            end
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe    <= 1'b0;
                                in_ack    <= 1'b1;
                                nack_seen <= 1'b0;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_oe  <= ~shreg[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: the data-line driver only moves on a falling SCL edge or a bus condition
    a_r9_oe_on_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_ev || stop_ev));

    // R10: a write strobe lasts exactly one cycle
    a_r10_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R3: every write strobe follows a falling SCL edge that ended a data byte
    a_r3_wr_after_scl_fall: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_fall));

    // R8: the completion pulse always follows a detected stop
    a_r8_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(stop_ev));
endmodule

// File: rtl/smb_regslave.sv
// SMBus-compatible register slave (top level).
// Joins the line monitor and the transfer engine. Register storage, read-only
// bits and self-clearing bits live outside this block.
// Assumes clk runs at least about 8 times faster than SCL.
module smb_regslave #(
    parameter logic [6:0] SLV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          skip_count,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          xfer_done
);
    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    smb_line_mon #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_xfer_fsm #(
        .SLV_ADDR (SLV_ADDR),
        .NUM_REGS (NUM_REGS),
        .AW       (AW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .skip_count (skip_count),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .done       (xfer_done)
    );
endmodule

// File: tb/smb_regslave_tb.sv
module smb_regslave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic skip_count = 1'b0;
    logic sda_oe, wr_en, xfer_done;
    logic [2:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic sda_bus;

    logic [7:0] mem [NREG];
    logic [7:0] expv [NREG];
    logic [7:0] rbuf [16];
    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    int wr_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = mem[rd_addr];

    smb_regslave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .skip_count(skip_count), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .xfer_done(xfer_done)
    );

    // Register model, plus counters for write strobes and completion pulses.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= 8'(8'h10 + i);
        end else begin
            if (wr_en) begin mem[wr_addr] <= wr_data; wr_cnt++; end
            if (xfer_done) done_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q(); q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; q(); scl = 1'b1; q(); b = sda_bus; q(); scl = 1'b0; q();
    endtask

    // Returns the acknowledge bit seen on the bus (0 = acknowledged).
    task automatic send_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(nack);
    endtask

    task automatic byte_write(input int off, input logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte(8'hD2, acks[2]);
        send_byte(8'(8'h80 | off), acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic byte_read(input int off, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'(8'h80 | off), a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(d, 1'b1);
        bus_stop();
    endtask

    // Reads the count byte and n data bytes; rbuf[0] holds the count.
    task automatic block_read(input int n);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(d, 1'b0);
        rbuf[0] = d;
        for (int i = 1; i <= n; i++) begin
            recv_byte(d, (i == n));
            rbuf[i] = d;
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0] acks;
        logic a;
        logic [7:0] d;
        int base_done, base_wr;
        for (int i = 0; i < NREG; i++) expv[i] = 8'(8'h10 + i);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // Reset state (R9, R10, R8)
        check("R9 reset sda_oe", sda_oe, 0);
        check("R10 reset wr_en", wr_en, 0);
        check("R8 reset done", xfer_done, 0);

        // R2/R3/R8: single-byte writes sweeping every offset
        for (int o = 0; o < NREG; o++) begin
            base_done = done_cnt;
            byte_write(o, 8'(o * 29 + 3), acks);
            expv[o] = 8'(o * 29 + 3);
            check("R3 byte write acks", acks, 0);
            check("R8 one done per write", done_cnt - base_done, 1);
        end
        // R4/R8: single-byte reads of every offset, no done pulse
        base_done = done_cnt;
        for (int o = 0; o < NREG; o++) begin
            byte_read(o, d);
            check("R4 byte read data", d, expv[o]);
        end
        check("R8 no done on reads", done_cnt - base_done, 0);

        // R1: foreign address is not acknowledged and the bus is ignored
        base_wr = wr_cnt; base_done = done_cnt;
        bus_start();
        send_byte(8'hA4, a);
        check("R1 foreign address nack", a, 1);
        send_byte(8'h85, a);
        check("R1 ignored command nack", a, 1);
        send_byte(8'h55, a);
        bus_stop();
        check("R1 no write after foreign address", wr_cnt - base_wr, 0);
        check("R8 no done after foreign address", done_cnt - base_done, 0);
        byte_read(5, d);
        check("R1 reg5 unchanged", d, expv[5]);

        // R3: a second data byte in a single-byte write is refused
        base_wr = wr_cnt;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h82, a);
        send_byte(8'hAA, a);
        check("R3 first data ack", a, 0);
        send_byte(8'hBB, a);
        check("R3 second data nack", a, 1);
        bus_stop();
        expv[2] = 8'hAA;
        check("R3 one strobe", wr_cnt - base_wr, 1);
        byte_read(2, d);
        check("R3 reg2 holds first byte", d, 8'hAA);

        // R2: an offset beyond the bank is refused
        base_wr = wr_cnt; base_done = done_cnt;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h8A, a);
        check("R2 out-of-range command ack", a, 0);
        send_byte(8'h77, a);
        check("R2 out-of-range data nack", a, 1);
        bus_stop();
        check("R2 no write out of range", wr_cnt - base_wr, 0);
        check("R8 no done when nothing written", done_cnt - base_done, 0);

        // R5: block write with a count byte (skip_count = 0)
        skip_count = 1'b0;
        base_wr = wr_cnt;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'(NREG), a);
        check("R5 count ack", a, 0);
        for (int i = 0; i < NREG; i++) begin
            send_byte(8'(i * 17 + 8'h40), a);
            expv[i] = 8'(i * 17 + 8'h40);
            check("R5 block data ack", a, 0);
        end
        bus_stop();
        check("R5 count not written", wr_cnt - base_wr, NREG);

        // R7: block read returns the count, data ascending, then fill past the end
        block_read(NREG + 1);
        check("R7 count byte", rbuf[0], NREG);
        for (int i = 0; i < NREG; i++) check("R7 block read data", rbuf[i + 1], expv[i]);
        check("R7 read past end fill", rbuf[NREG + 1], 8'hFF);

        // R5/R6: block write without a count byte, stopped after three bytes
        skip_count = 1'b1;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'(8'hC0 ^ i), a);
            expv[i] = 8'(8'hC0 ^ i);
        end
        bus_stop();
        for (int o = 0; o < NREG; o++) begin
            byte_read(o, d);
            check("R6 early stop contents", d, expv[o]);
        end

        // R6: a block write past the last register is refused at the extra byte
        base_wr = wr_cnt;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        for (int i = 0; i <= NREG; i++) begin
            send_byte(8'(8'h90 + i), a);
            check("R6 block ack up to end", a, (i == NREG) ? 1 : 0);
            if (i < NREG) expv[i] = 8'(8'h90 + i);
        end
        bus_stop();
        check("R6 strobes limited to bank", wr_cnt - base_wr, NREG);
        block_read(NREG);
        for (int i = 0; i < NREG; i++) check("R7 final block read", rbuf[i + 1], expv[i]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule